// File: doc/BRIEF.md
# Frequency Hop Sequencer

The block produces the retune commands for the mixer oscillators of a data converter pair. One oscillator port serves the transmit path and one serves the receive path. Each path has its own start, stop and step frequency and its own phase word. A single dwell timer sets the hop rate for both paths, so the two ports always retune in the same clock cycle. At every hop the block presents a new frequency word and a new phase word on each port, together with a one-cycle update strobe. The first update after the sequencer is enabled also carries an oscillator reset strobe.

Frequencies are signed two's complement words scaled as f·2^48/fs, where fs is the converter rate of 2048 MS/s. A receive range can therefore sit at negative frequencies. Each hop adds the step word. When the result would run past the stop value, the sequence returns to the start value. A zero step pins a path at its start frequency. Settings arrive through a small write-only register port and are held in shadow registers. They reach the oscillator ports only at a hop boundary, or while the sequencer is disabled. The block runs on the 256 MHz stream clock, and its default dwell of 8192 cycles gives a 32 us hop period.

Top module: `hop_sequencer`

## Requirements
- R1: While reset is held and after it is released, with enable low, both frequency outputs and both phase outputs read 0, and no update or oscillator reset strobe is asserted.
- R2: The reset defaults of both paths are start 0, stop 500·2^37 (500 MHz), step 25·2^37 (25 MHz) and phase 0. The default dwell is 8192 cycles.
- R3: When enable is high at a clock edge that follows a cycle with enable low (or reset), both update outputs pulse in that cycle. After that they pulse once every max(dwell,1) cycles. The transmit and receive pulses always coincide.
- R4: The oscillator reset outputs pulse only together with the first update after enable rises, and never at a later hop.
- R5: At each hop a path's frequency becomes previous + step. If that sum is greater than stop for a step ≥ 0, or less than stop for a negative step, the frequency becomes start instead. This includes negative ranges.
- R6: A path with a step of 0 stays at its start frequency at every hop, while it still issues its update pulses.
- R7: While enable stays high, the frequency and phase outputs change only in a cycle with an update pulse.
- R8: A register write made while the sequencer runs has no effect on the outputs before the next hop. The step, stop and phase written are used at that hop. A new dwell first sets the interval that follows that hop.
- R9: While enable is low, no update or reset strobe is issued, each frequency output shows its path's start value, and the dwell timer is cleared.
- R10: The write address selects a field of a path as path·4 + field, with path 0 = transmit and path 1 = receive, and field 0 = start, 1 = stop, 2 = step, 3 = phase. Address 8 holds the dwell. Writes to addresses 9 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stream clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the hop sequence; low holds both paths at start |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register write address |
| cfg_wdata | input | 48 | Register write data (phase and dwell use the low bits) |
| tx_freq | output | 48 | Transmit oscillator frequency word |
| tx_phase | output | 18 | Transmit oscillator phase word |
| tx_nco_rst | output | 1 | Transmit oscillator reset strobe |
| tx_update | output | 1 | Transmit retune event |
| rx_freq | output | 48 | Receive oscillator frequency word |
| rx_phase | output | 18 | Receive oscillator phase word |
| rx_nco_rst | output | 1 | Receive oscillator reset strobe |
| rx_update | output | 1 | Receive retune event |

## Verification
Every output comes from one register, so a result appears at the first clock edge that samples its cause. The start pulse lands at the edge that first sees enable high. A hop lands exactly max(dwell,1) edges after the previous one. A write takes effect at the edge that samples it, while the outputs it feeds move only at the following hop. The bench therefore drives enable and writes on falling edges. It counts falling edges from the one after the enabling edge, calling that count t = 0. For every t it predicts pulses at multiples of the dwell and frequencies equal to start + ((t div dwell) mod L)·step, where L is the number of entries in the list. It compares these at each falling edge for swept dwells and steps.

// File: rtl/hop_seq_pkg.sv
package hop_seq_pkg;

    // Field selector within one path's group of four registers.
    typedef enum logic [1:0] {
        FLD_START = 2'd0,
        FLD_STOP  = 2'd1,
        FLD_STEP  = 2'd2,
        FLD_PHASE = 2'd3
    } hop_fld_e;

    localparam int unsigned HOP_FIELDS = 4;
    localparam int unsigned HOP_NPATH  = 2;   // 0 = transmit, 1 = receive

    // Frequency word for a whole number of MHz at a converter rate of conv_mhz.
    function automatic longint unsigned mhz_to_word(input int unsigned mhz,
                                                    input int unsigned conv_mhz,
                                                    input int unsigned frac_bits);
        longint unsigned num;
        num = longint'(mhz) << frac_bits;
        return num / longint'(conv_mhz);
    endfunction

endpackage

// File: rtl/hop_cfg_regs.sv
module hop_cfg_regs
    import hop_seq_pkg::*;
#(
    parameter int unsigned FREQ_W    = 48,
    parameter int unsigned PH_W      = 18,
    parameter int unsigned DWELL_W   = 28,
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned NPATH     = 2,
    parameter logic [FREQ_W-1:0]  DEF_STOP  = '0,
    parameter logic [FREQ_W-1:0]  DEF_STEP  = '0,
    parameter logic [DWELL_W-1:0] DEF_DWELL = '0
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [FREQ_W-1:0]               wdata,
    output logic [NPATH-1:0][FREQ_W-1:0]    sh_start,
    output logic [NPATH-1:0][FREQ_W-1:0]    sh_stop,
    output logic [NPATH-1:0][FREQ_W-1:0]    sh_step,
    output logic [NPATH-1:0][PH_W-1:0]      sh_phase,
    output logic [DWELL_W-1:0]              sh_dwell
);

    localparam int unsigned GRP_W     = ADDR_W - 2;
    localparam logic [GRP_W-1:0] DWELL_GRP = GRP_W'(NPATH);

    typedef struct packed {
        logic [NPATH-1:0][FREQ_W-1:0] start;
        logic [NPATH-1:0][FREQ_W-1:0] stop;
        logic [NPATH-1:0][FREQ_W-1:0] step;
        logic [NPATH-1:0][PH_W-1:0]   phase;
        logic [DWELL_W-1:0]           dwell;
    } regs_t;

    regs_t r_d, r_q;

    logic [GRP_W-1:0] grp;
    hop_fld_e         fld;

    assign grp = addr[ADDR_W-1:2];
    assign fld = hop_fld_e'(addr[1:0]);

    always_comb begin
        r_d = r_q;
        if (we) begin
            for (int p = 0; p < int'(NPATH); p++) begin
                if (grp == GRP_W'(p)) begin
                    unique case (fld)
                        FLD_START: r_d.start[p] = wdata;
                        FLD_STOP:  r_d.stop[p]  = wdata;
                        FLD_STEP:  r_d.step[p]  = wdata;
                        FLD_PHASE: r_d.phase[p] = wdata[PH_W-1:0];
                        default:   ;
                    endcase
                end
            end
            if (grp == DWELL_GRP && fld == FLD_START) begin
                r_d.dwell = wdata[DWELL_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < int'(NPATH); p++) begin
                r_q.start[p] <= '0;
                r_q.stop[p]  <= DEF_STOP;
                r_q.step[p]  <= DEF_STEP;
                r_q.phase[p] <= '0;
            end
            r_q.dwell <= DEF_DWELL;
        end else begin
            r_q <= r_d;
        end
    end

    assign sh_start = r_q.start;
    assign sh_stop  = r_q.stop;
    assign sh_step  = r_q.step;
    assign sh_phase = r_q.phase;
    assign sh_dwell = r_q.dwell;

endmodule

// File: rtl/hop_path_step.sv
module hop_path_step #(
    parameter int unsigned FREQ_W = 48
) (
    input  logic [FREQ_W-1:0] cur,
    input  logic [FREQ_W-1:0] start,
    input  logic [FREQ_W-1:0] stop,
    input  logic [FREQ_W-1:0] step,
    output logic [FREQ_W-1:0] nxt
);

    localparam int unsigned EXT_W = FREQ_W + 1;

    logic signed [EXT_W-1:0] sum_x;
    logic signed [EXT_W-1:0] stop_x;
    logic                    descending;
    logic                    overrun;

    always_comb begin
        // One guard bit so the comparison sees the true sum even near full scale.
        sum_x      = $signed({cur[FREQ_W-1], cur}) + $signed({step[FREQ_W-1], step});
        stop_x     = $signed({stop[FREQ_W-1], stop});
        descending = step[FREQ_W-1];
        overrun    = descending ? (sum_x < stop_x) : (sum_x > stop_x);
        nxt        = overrun ? start : sum_x[FREQ_W-1:0];
    end

endmodule

// File: rtl/hop_dwell_timer.sv
module hop_dwell_timer #(
    parameter int unsigned DWELL_W = 28,
    parameter logic [DWELL_W-1:0] DEF_DWELL = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic [DWELL_W-1:0] dwell_in,
    output logic               tick
);

    typedef struct packed {
        logic [DWELL_W-1:0] cnt;
        logic [DWELL_W-1:0] limit;
    } tmr_t;

    tmr_t t_d, t_q;
    logic [DWELL_W:0] cnt_plus;

    always_comb begin
        t_d      = t_q;
        cnt_plus = {1'b0, t_q.cnt} + 1'b1;
        tick     = 1'b0;
        if (clear) begin
            t_d.cnt   = '0;
            t_d.limit = dwell_in;
        end else if (cnt_plus >= {1'b0, t_q.limit}) begin
            tick      = 1'b1;
            t_d.cnt   = '0;
            t_d.limit = dwell_in;
        end else begin
            t_d.cnt = cnt_plus[DWELL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.cnt   <= '0;
            t_q.limit <= DEF_DWELL;
        end else begin
            t_q <= t_d;
        end
    end

endmodule

// File: rtl/hop_sequencer.sv
module hop_sequencer
    import hop_seq_pkg::*;
#(
    parameter int unsigned FREQ_W       = 48,
    parameter int unsigned PH_W         = 18,
    parameter int unsigned DWELL_W      = 28,
    parameter int unsigned ADDR_W       = 4,
    parameter int unsigned CONV_MHZ     = 2048,
    parameter int unsigned DEF_STEP_MHZ = 25,
    parameter int unsigned DEF_STOP_MHZ = 500,
    parameter int unsigned DEF_DWELL    = 8192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [FREQ_W-1:0] cfg_wdata,
    output logic [FREQ_W-1:0] tx_freq,
    output logic [PH_W-1:0]   tx_phase,
    output logic              tx_nco_rst,
    output logic              tx_update,
    output logic [FREQ_W-1:0] rx_freq,
    output logic [PH_W-1:0]   rx_phase,
    output logic              rx_nco_rst,
    output logic              rx_update
);

    localparam int unsigned NPATH = HOP_NPATH;
    localparam logic [FREQ_W-1:0] DEF_STEP_W =
        FREQ_W'(mhz_to_word(DEF_STEP_MHZ, CONV_MHZ, FREQ_W));
    localparam logic [FREQ_W-1:0] DEF_STOP_W =
        FREQ_W'(mhz_to_word(DEF_STOP_MHZ, CONV_MHZ, FREQ_W));
    localparam logic [DWELL_W-1:0] DEF_DWELL_W = DWELL_W'(DEF_DWELL);

    typedef struct packed {
        logic                         armed;
        logic                         upd;
        logic                         nrst;
        logic [NPATH-1:0][FREQ_W-1:0] freq;
        logic [NPATH-1:0][PH_W-1:0]   phase;
    } seq_t;

    logic [NPATH-1:0][FREQ_W-1:0] sh_start, sh_stop, sh_step, nxt_freq;
    logic [NPATH-1:0][PH_W-1:0]   sh_phase;
    logic [DWELL_W-1:0]           sh_dwell;
    logic                         tmr_clear;
    logic                         tmr_tick;

    seq_t st_d, st_q;

    hop_cfg_regs #(
        .FREQ_W    (FREQ_W),
        .PH_W      (PH_W),
        .DWELL_W   (DWELL_W),
        .ADDR_W    (ADDR_W),
        .NPATH     (NPATH),
        .DEF_STOP  (DEF_STOP_W),
        .DEF_STEP  (DEF_STEP_W),
        .DEF_DWELL (DEF_DWELL_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .sh_start (sh_start),
        .sh_stop  (sh_stop),
        .sh_step  (sh_step),
        .sh_phase (sh_phase),
        .sh_dwell (sh_dwell)
    );

    for (genvar p = 0; p < int'(NPATH); p++) begin : g_path
        hop_path_step #(
            .FREQ_W (FREQ_W)
        ) u_step (
            .cur   (st_q.freq[p]),
            .start (sh_start[p]),
            .stop  (sh_stop[p]),
            .step  (sh_step[p]),
            .nxt   (nxt_freq[p])
        );
    end

    assign tmr_clear = !enable || st_q.armed;

    hop_dwell_timer #(
        .DWELL_W   (DWELL_W),
        .DEF_DWELL (DEF_DWELL_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (tmr_clear),
        .dwell_in (sh_dwell),
        .tick     (tmr_tick)
    );

    always_comb begin
        st_d      = st_q;
        st_d.upd  = 1'b0;
        st_d.nrst = 1'b0;
        if (!enable) begin
            st_d.armed = 1'b1;
            st_d.freq  = sh_start;
            st_d.phase = sh_phase;
        end else if (st_q.armed) begin
            st_d.armed = 1'b0;
            st_d.upd   = 1'b1;
            st_d.nrst  = 1'b1;
            st_d.freq  = sh_start;
            st_d.phase = sh_phase;
        end else if (tmr_tick) begin
            st_d.upd   = 1'b1;
            st_d.freq  = nxt_freq;
            st_d.phase = sh_phase;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.armed <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_freq    = st_q.freq[0];
    assign tx_phase   = st_q.phase[0];
    assign tx_nco_rst = st_q.nrst;
    assign tx_update  = st_q.upd;
    assign rx_freq    = st_q.freq[1];
    assign rx_phase   = st_q.phase[1];
    assign rx_nco_rst = st_q.nrst;
    assign rx_update  = st_q.upd;

endmodule

// File: rtl/hop_sequencer_chk.sv
module hop_sequencer_chk #(
    parameter int unsigned FREQ_W = 48,
    parameter int unsigned PH_W   = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic [FREQ_W-1:0] tx_freq,
    input logic [PH_W-1:0]   tx_phase,
    input logic              tx_nco_rst,
    input logic              tx_update,
    input logic [FREQ_W-1:0] rx_freq,
    input logic [PH_W-1:0]   rx_phase,
    input logic              rx_nco_rst,
    input logic              rx_update
);

    // R3: both ports retune in the same cycle
    a_r3_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
        tx_update == rx_update);

    // R4: an oscillator reset is always accompanied by an update
    a_r4_rst_with_upd: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_nco_rst || rx_nco_rst) |-> (tx_update && rx_update));

    // R4: the reset strobe never lasts two cycles
    a_r4_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
        tx_nco_rst |=> !tx_nco_rst);

    // R7: words hold between update pulses while running
    a_r7_tx_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_update && $past(enable)) |-> ($stable(tx_freq) && $stable(tx_phase)));

    a_r7_rx_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_update && $past(enable)) |-> ($stable(rx_freq) && $stable(rx_phase)));

    // R9: no strobes follow a cycle with enable low
    a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> !(tx_update || rx_update || tx_nco_rst || rx_nco_rst));

endmodule

bind hop_sequencer hop_sequencer_chk #(
    .FREQ_W (FREQ_W),
    .PH_W   (PH_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .tx_freq    (tx_freq),
    .tx_phase   (tx_phase),
    .tx_nco_rst (tx_nco_rst),
    .tx_update  (tx_update),
    .rx_freq    (rx_freq),
    .rx_phase   (rx_phase),
    .rx_nco_rst (rx_nco_rst),
    .rx_update  (rx_update)
);

// File: tb/tb_hop_sequencer.sv
module tb_hop_sequencer;

    localparam int FW = 48;
    localparam int PW = 18;
    localparam longint W37 = longint'(1) << 37;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          cfg_we = 1'b0;
    logic [3:0]    cfg_addr = '0;
    logic [FW-1:0] cfg_wdata = '0;
    logic [FW-1:0] tx_freq, rx_freq;
    logic [PW-1:0] tx_phase, rx_phase;
    logic          tx_nco_rst, tx_update, rx_nco_rst, rx_update;

    int n_chk = 0;
    int n_bad = 0;

    // model configuration, index 0 = transmit, 1 = receive
    longint m_start[2];
    longint m_stop[2];
    longint m_step[2];
    longint m_phase[2];
    longint m_dwell;

    always #2.5 clk = ~clk;

    hop_sequencer dut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .tx_freq(tx_freq), .tx_phase(tx_phase), .tx_nco_rst(tx_nco_rst), .tx_update(tx_update),
        .rx_freq(rx_freq), .rx_phase(rx_phase), .rx_nco_rst(rx_nco_rst), .rx_update(rx_update)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic longint get_f(input int p);
        return (p == 0) ? longint'($signed(tx_freq)) : longint'($signed(rx_freq));
    endfunction
    function automatic longint get_ph(input int p);
        return (p == 0) ? longint'(tx_phase) : longint'(rx_phase);
    endfunction
    function automatic bit get_u(input int p);
        return (p == 0) ? tx_update : rx_update;
    endfunction
    function automatic bit get_r(input int p);
        return (p == 0) ? tx_nco_rst : rx_nco_rst;
    endfunction

    function automatic longint exp_freq(input int p, input int t);
        longint d, k, len;
        d = (m_dwell < 1) ? 1 : m_dwell;
        k = t / d;
        if (m_step[p] == 0) return m_start[p];
        len = (m_stop[p] - m_start[p]) / m_step[p] + 1;
        if (len < 1) len = 1;
        return m_start[p] + (k % len) * m_step[p];
    endfunction

    // called at a falling edge
    task automatic wr(input int addr, input longint data);
        cfg_we    = 1'b1;
        cfg_addr  = 4'(addr);
        cfg_wdata = FW'(data);
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic check_cycle(input int t);
        longint d;
        d = (m_dwell < 1) ? 1 : m_dwell;
        for (int p = 0; p < 2; p++) begin
            chk(get_u(p) == ((t % d) == 0), "R3 update timing", longint'(get_u(p)), longint'((t % d) == 0));
            chk(get_r(p) == (t == 0), "R4 reset strobe", longint'(get_r(p)), longint'(t == 0));
            chk(get_f(p) == exp_freq(p, t), "R5 R6 frequency", get_f(p), exp_freq(p, t));
            chk(get_ph(p) == m_phase[p], "R8 phase word", get_ph(p), m_phase[p]);
        end
    endtask

    task automatic program_model;
        for (int p = 0; p < 2; p++) begin
            wr(p * 4 + 0, m_start[p]);
            wr(p * 4 + 1, m_stop[p]);
            wr(p * 4 + 2, m_step[p]);
            wr(p * 4 + 3, m_phase[p]);
        end
        wr(8, m_dwell);
    endtask

    // disable, program, enable and compare for ncyc cycles, then disable
    task automatic run_case(input int ncyc);
        enable = 1'b0;
        @(negedge clk);
        program_model();
        @(negedge clk);
        // R9: while disabled, start values shown and no strobes
        for (int p = 0; p < 2; p++) begin
            chk(get_f(p) == m_start[p], "R9 start while disabled", get_f(p), m_start[p]);
            chk(!get_u(p) && !get_r(p), "R9 no strobe while disabled", longint'(get_u(p)), 0);
        end
        enable = 1'b1;
        for (int t = 0; t < ncyc; t++) begin
            @(negedge clk);
            check_cycle(t);
        end
        enable = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            for (int p = 0; p < 2; p++) begin
                chk(get_f(p) == m_start[p], "R9 reload start on disable", get_f(p), m_start[p]);
                chk(!get_u(p), "R9 no update on disable", longint'(get_u(p)), 0);
            end
        end
    endtask

    initial begin
        #(150000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(tx_freq == 0 && rx_freq == 0, "R1 freq in reset", longint'(tx_freq), 0);
        chk(!tx_update && !rx_update && !tx_nco_rst && !rx_nco_rst, "R1 strobes in reset", longint'(tx_update), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(tx_freq == 0 && rx_freq == 0 && tx_phase == 0 && rx_phase == 0, "R1 after reset", longint'(tx_freq), 0);
        chk(!tx_update && !tx_nco_rst, "R1 no strobe after reset", longint'(tx_update), 0);

        // R2: defaults, no writes
        for (int p = 0; p < 2; p++) begin
            m_start[p] = 0; m_stop[p] = 500 * W37; m_step[p] = 25 * W37; m_phase[p] = 0;
        end
        m_dwell = 8192;
        enable = 1'b1;
        for (int t = 0; t < 8192 * 2 + 2; t++) begin
            @(negedge clk);
            check_cycle(t); // R2 default dwell and step
        end
        enable = 1'b0;
        @(negedge clk);

        // R10: writes to unused addresses must change nothing
        for (int a = 9; a < 16; a++) wr(a, -1);

        // R5: ascending and negative descending ranges
        m_start[0] = 0;   m_stop[0] = 100;  m_step[0] = 10;  m_phase[0] = 1234;
        m_start[1] = 0;   m_stop[1] = -30;  m_step[1] = -7;  m_phase[1] = 77;
        m_dwell = 3;
        run_case(60);

        // near-exhaustive sweep over dwell and step, R6 receive held fixed
        for (int d = 0; d < 5; d++) begin
            for (int s = 1; s < 4; s++) begin
                m_start[0] = -5;   m_stop[0] = 5;     m_step[0] = s;  m_phase[0] = d * 16 + s;
                m_start[1] = -500; m_stop[1] = -500;  m_step[1] = 0;  m_phase[1] = 3;
                m_dwell = d;
                run_case(30);
            end
        end

        // R5: step larger than range, and start beyond stop
        m_start[0] = 10; m_stop[0] = 12; m_step[0] = 5;  m_phase[0] = 0;
        m_start[1] = 10; m_stop[1] = 5;  m_step[1] = 1;  m_phase[1] = 9;
        m_dwell = 2;
        run_case(12);

        // R8: deferred configuration while running
        m_start[0] = 0; m_stop[0] = 100; m_step[0] = 10; m_phase[0] = 0;
        m_start[1] = 0; m_stop[1] = 100; m_step[1] = 10; m_phase[1] = 0;
        m_dwell = 8;
        enable = 1'b0;
        @(negedge clk);
        program_model();
        enable = 1'b1;
        for (int t = 0; t < 13; t++) begin
            bit eu;
            longint etx, erx;
            @(negedge clk);
            eu  = (t == 0 || t == 8 || t == 11);
            etx = (t < 8) ? 0 : (t < 11) ? 20 : 40;
            erx = (t < 8) ? 0 : (t < 11) ? 10 : 20;
            chk(tx_update == eu && rx_update == eu, "R8 update after deferred dwell", longint'(tx_update), longint'(eu));
            chk(get_f(0) == etx, "R8 tx deferred step", get_f(0), etx);
            chk(get_f(1) == erx, "R8 rx unaffected", get_f(1), erx);
            if (t == 3) begin
                cfg_we = 1'b1; cfg_addr = 4'd2; cfg_wdata = FW'(20);
            end else if (t == 4) begin
                cfg_we = 1'b1; cfg_addr = 4'd8; cfg_wdata = FW'(3);
            end else begin
                cfg_we = 1'b0;
            end
        end
        enable = 1'b0;
        @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule